// File: doc/BRIEF.md
# SD/MMC Host Command Path Controller

This block is the host side of the command line of an SD/MMC-style card bus. Software sets up a 6-bit command index, a 32-bit argument and a 2-bit response selection, then pulses `start`. The block forms a 48-bit token with a computed CRC7 and shifts it out one bit per clock on `cmd_out`, with `cmd_oe` high. When a reply is expected, it releases the line and watches `cmd_in` for a start bit. It then shifts in a short (48-bit) or long (136-bit) reply and checks its CRC. If no start bit arrives in time, it reports a timeout. Before it accepts the next command, the block always spends a fixed idle gap.

Completion is reported through four sticky flags, which software clears by writing ones. Two further uses are supported. In a hold-low boot sequence, the line stays low until software drops the boot enable. In a boot-command sequence, a rising boot enable launches an ordinary token. A wait-pending control holds a fully formed token until the data path signals that it is ready. `cmd_in` is sampled on every rising clock edge. One clock period equals one bit time on the card bus.

Top module: `sdcmd_path`

## Requirements
- R1: A token is 48 bits and is sent on 48 consecutive clocks with `cmd_oe` high, bit 47 first. Bit 47 is 0, bit 46 is 1, bits 45..40 hold `cmd_index`, bits 39..8 hold `cmd_arg`, bits 7..1 hold the CRC7 and bit 0 is 1. The index and argument are captured on the clock where the command is accepted.
- R2: The CRC7 uses the polynomial x^7 + x^3 + 1 with a zero seed and runs over token bits 47 down to 8. For index 0 with argument 0 the token is 0x400000000095. For index 8 with argument 0x1AA it is 0x48000001AA87.
- R3: `resp_sel` = 2'b00 expects no reply. The sent flag (`flags[0]`) is set on the clock edge after which the last token bit is no longer driven.
- R4: `resp_sel` = 2'b01 receives a 48-bit reply MSB first, starting at its 0 start bit. The block checks the reply's bits 7..1 against the CRC7 of its bits 47..8 and sets `flags[1]` (good) or `flags[2]` (CRC error). `resp_word[47:0]` then holds the whole reply.
- R5: `resp_sel` = 2'b10 receives a 48-bit reply and sets `flags[1]` whatever its CRC field holds.
- R6: `resp_sel` = 2'b11 receives a 136-bit reply. The CRC check covers bits 127..8 against bits 7..1. `resp_word` then holds reply bits 127..0.
- R7: After the token, the block samples `cmd_in` on 64 clocks for a start bit. A start bit driven on the 64th of these clocks is accepted. If none arrives, `flags[3]` is set exactly 64 clocks after `cmd_oe` drops.
- R8: After any completion, `ready` stays low for exactly 8 clocks. A `start` pulse while `ready` is low is ignored and sends nothing.
- R9: With `boot_mode` = 0, a rising `boot_en` while `ready` drives the line low (`cmd_oe` = 1, `cmd_out` = 0) until `boot_en` falls. Then `cmd_out` returns high, `cmd_oe` drops and `abort_pulse` is high for exactly one clock.
- R10: In the hold-low boot sequence, `flags[0]` is first seen 56 clocks after `cmd_out` is first seen high again.
- R11: With `boot_mode` = 1, a rising `boot_en` while `ready` sends a normal token. Clearing `boot_en` during that token has no effect: the token completes and no abort is issued.
- R12: If `wait_pend` is high when a command is accepted, the token waits with `cmd_oe` low until `dpath_ready` is high or `wait_pend` is low. Input changes during the wait do not alter the token.
- R13: The flags are sticky. A 1 in `flags_clr[i]` clears `flags[i]` only, and a set on the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a command when `ready` |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_sel | input | 2 | Response kind: 00 none, 01 short+CRC, 10 short no CRC, 11 long |
| wait_pend | input | 1 | Hold the token until the data path is ready |
| dpath_ready | input | 1 | Data path ready, releases a held token |
| boot_en | input | 1 | Boot enable |
| boot_mode | input | 1 | 0 hold-low boot, 1 boot command |
| cmd_in | input | 1 | Sampled command line |
| cmd_out | output | 1 | Value driven on the command line |
| cmd_oe | output | 1 | Drive enable for the command line |
| abort_pulse | output | 1 | One-clock abort to the data path at boot end |
| ready | output | 1 | Idle and able to accept a command |
| flags | output | 4 | Sticky: [0] sent, [1] reply good, [2] CRC error, [3] timeout |
| flags_clr | input | 4 | Write-one-to-clear for `flags` |
| resp_word | output | 128 | Received reply bits, right-aligned |

## Verification
The hardest case to reach is a reply whose start bit lands on the very last sampled clock of the timeout window. One clock later and the same stimulus must produce a timeout instead. The bench captures the token bit by bit. It counts clocks from the first clock where `cmd_oe` is low, then drives the start bit on clock 63 in one test and sends nothing in another, so both sides of the boundary are hit. The 56-clock boot tail and the 8-clock idle gap are measured the same way from a visible line event. During the gap, a start pulse is injected to show it is dropped.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int TOKEN_W    = 48;
    localparam int SHORT_W    = 48;
    localparam int LONG_W     = 136;
    localparam int CRC_W      = 7;
    localparam int RESP_OUT_W = 128;
    localparam int LONG_HDR   = LONG_W - RESP_OUT_W;
    localparam int NFLAGS     = 4;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    localparam int F_SENT = 0;
    localparam int F_OK   = 1;
    localparam int F_CRC  = 2;
    localparam int F_TO   = 3;

    typedef enum logic [1:0] {
        RESP_NONE        = 2'b00,
        RESP_SHORT       = 2'b01,
        RESP_SHORT_NOCRC = 2'b10,
        RESP_LONG        = 2'b11
    } resp_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GAP,
        ST_PEND,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_CHECK,
        ST_BOOT,
        ST_TAIL
    } state_t;

    typedef struct packed {
        logic       lead0;
        logic       dir1;
        logic [5:0] index;
        logic [31:0] arg;
        logic [CRC_W-1:0] crc;
        logic       stop1;
    } token_t;

    function automatic logic [CRC_W-1:0] crc7_step(logic [CRC_W-1:0] c, logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic [CRC_W-1:0] crc7_over40(logic [39:0] d);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = 39; i >= 0; i--) c = crc7_step(c, d[i]);
        return c;
    endfunction

    function automatic token_t build_token(logic [5:0] idx, logic [31:0] arg);
        token_t t;
        t.lead0 = 1'b0;
        t.dir1  = 1'b1;
        t.index = idx;
        t.arg   = arg;
        t.crc   = crc7_over40({t.lead0, t.dir1, idx, arg});
        t.stop1 = 1'b1;
        return t;
    endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_o
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) crc_q <= '0;
        else if (en)    crc_q <= crc7_step(crc_q, bit_in);
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
    import sdcmd_pkg::*;
#(
    parameter int W = TOKEN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] word_i,
    output logic         bit_o
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)        sh_q <= '1;
        else if (load)  sh_q <= word_i;
        else if (shift) sh_q <= {sh_q[W-2:0], 1'b1};
    end

    assign bit_o = sh_q[W-1];
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
    import sdcmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  arm,
    input  logic                  sample,
    input  logic                  bit_in,
    input  logic                  long_sel,
    output logic                  last,
    output logic                  crc_ok,
    output logic [RESP_OUT_W-1:0] data_o
);
    localparam int RCNT_W = $clog2(LONG_W + 1);
    localparam logic [RCNT_W-1:0] LEN_S  = RCNT_W'(SHORT_W);
    localparam logic [RCNT_W-1:0] LEN_L  = RCNT_W'(LONG_W);
    localparam logic [RCNT_W-1:0] SKIP_L = RCNT_W'(LONG_HDR);
    localparam logic [RCNT_W-1:0] TAILB  = RCNT_W'(CRC_W + 2);

    logic [LONG_W-1:0] data_q;
    logic [RCNT_W-1:0] cnt_q;
    logic [RCNT_W-1:0] len;
    logic [RCNT_W-1:0] lo;
    logic              feed;
    logic [CRC_W-1:0]  crc_acc;

    assign len  = long_sel ? LEN_L : LEN_S;
    assign lo   = long_sel ? SKIP_L : '0;
    assign feed = sample && (cnt_q >= lo) && (cnt_q <= len - TAILB);
    assign last = sample && (cnt_q == len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else if (sample) begin
            data_q <= {data_q[LONG_W-2:0], bit_in};
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    sdcmd_crc7 i_crc (
        .clk    (clk),
        .rst    (rst),
        .clr    (arm),
        .en     (feed),
        .bit_in (bit_in),
        .crc_o  (crc_acc)
    );

    assign crc_ok = (crc_acc == data_q[CRC_W:1]);
    assign data_o = data_q[RESP_OUT_W-1:0];
endmodule

// File: rtl/sdcmd_path.sv
module sdcmd_path
    import sdcmd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int GAP_CYC     = 8,
    parameter int TAIL_CYC    = 56
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [5:0]            cmd_index,
    input  logic [31:0]           cmd_arg,
    input  logic [1:0]            resp_sel,
    input  logic                  wait_pend,
    input  logic                  dpath_ready,
    input  logic                  boot_en,
    input  logic                  boot_mode,
    input  logic                  cmd_in,
    output logic                  cmd_out,
    output logic                  cmd_oe,
    output logic                  abort_pulse,
    output logic                  ready,
    output logic [NFLAGS-1:0]     flags,
    input  logic [NFLAGS-1:0]     flags_clr,
    output logic [RESP_OUT_W-1:0] resp_word
);
    localparam int MAXC  = (TIMEOUT_CYC > TAIL_CYC) ?
                           ((TIMEOUT_CYC > TOKEN_W) ? TIMEOUT_CYC : TOKEN_W) :
                           ((TAIL_CYC > TOKEN_W) ? TAIL_CYC : TOKEN_W);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] TOK_END = CNT_W'(TOKEN_W - 1);
    localparam logic [CNT_W-1:0] TO_END  = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_END = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] TL_END  = CNT_W'(TAIL_CYC - 1);

    state_t            state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    resp_t             rkind_q;
    logic              boot_q;
    logic              boot_rise;
    logic              go_cmd, go_boot;
    logic              tx_shift, tx_bit;
    logic              rx_arm, rx_sample, rx_last, rx_crc_ok;
    logic              abort_n, abort_q;
    logic [NFLAGS-1:0] set_vec;
    logic [NFLAGS-1:0] flag_q;
    token_t            tok;

    assign boot_rise = boot_en && !boot_q;
    assign go_cmd    = (state == ST_IDLE) && (start || (boot_rise && boot_mode));
    assign go_boot   = (state == ST_IDLE) && !start && boot_rise && !boot_mode;
    assign tok       = build_token(cmd_index, cmd_arg);

    sdcmd_tx #(.W(TOKEN_W)) i_tx (
        .clk    (clk),
        .rst    (rst),
        .load   (go_cmd),
        .shift  (tx_shift),
        .word_i (tok),
        .bit_o  (tx_bit)
    );

    sdcmd_rx i_rx (
        .clk      (clk),
        .rst      (rst),
        .arm      (rx_arm),
        .sample   (rx_sample),
        .bit_in   (cmd_in),
        .long_sel (rkind_q == RESP_LONG),
        .last     (rx_last),
        .crc_ok   (rx_crc_ok),
        .data_o   (resp_word)
    );

    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        set_vec   = '0;
        tx_shift  = 1'b0;
        rx_arm    = 1'b0;
        rx_sample = 1'b0;
        abort_n   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go_cmd) begin
                    state_n = wait_pend ? ST_PEND : ST_SEND;
                    cnt_n   = '0;
                end else if (go_boot) begin
                    state_n = ST_BOOT;
                end
            end
            ST_PEND: begin
                if (dpath_ready || !wait_pend) begin
                    state_n = ST_SEND;
                    cnt_n   = '0;
                end
            end
            ST_SEND: begin
                tx_shift = 1'b1;
                if (cnt == TOK_END) begin
                    cnt_n = '0;
                    if (rkind_q == RESP_NONE) begin
                        set_vec[F_SENT] = 1'b1;
                        state_n         = ST_GAP;
                    end else begin
                        rx_arm  = 1'b1;
                        state_n = ST_WAIT;
                    end
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (!cmd_in) begin
                    rx_sample = 1'b1;
                    state_n   = ST_RECV;
                end else if (cnt == TO_END) begin
                    set_vec[F_TO] = 1'b1;
                    state_n       = ST_GAP;
                    cnt_n         = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_RECV: begin
                rx_sample = 1'b1;
                if (rx_last) state_n = ST_CHECK;
            end
            ST_CHECK: begin
                if (rkind_q == RESP_SHORT_NOCRC || rx_crc_ok) set_vec[F_OK]  = 1'b1;
                else                                          set_vec[F_CRC] = 1'b1;
                state_n = ST_GAP;
                cnt_n   = '0;
            end
            ST_GAP: begin
                if (cnt == GAP_END) state_n = ST_IDLE;
                else                cnt_n   = cnt + 1'b1;
            end
            ST_BOOT: begin
                if (!boot_en) begin
                    abort_n = 1'b1;
                    state_n = ST_TAIL;
                    cnt_n   = '0;
                end
            end
            ST_TAIL: begin
                if (cnt == TL_END) begin
                    set_vec[F_SENT] = 1'b1;
                    state_n         = ST_GAP;
                    cnt_n           = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            rkind_q <= RESP_NONE;
            boot_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            boot_q  <= boot_en;
            abort_q <= abort_n;
            if (go_cmd) rkind_q <= resp_t'(resp_sel);
        end
    end

    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)               flag_q[g] <= 1'b0;
            else if (set_vec[g])   flag_q[g] <= 1'b1;
            else if (flags_clr[g]) flag_q[g] <= 1'b0;
        end
    end

    assign flags       = flag_q;
    assign abort_pulse = abort_q;
    assign ready       = (state == ST_IDLE);
    assign cmd_oe      = (state == ST_SEND) || (state == ST_BOOT);
    assign cmd_out     = (state == ST_SEND) ? tx_bit : (state != ST_BOOT);
endmodule

// File: rtl/sdcmd_path_chk.sv
module sdcmd_path_chk
    import sdcmd_pkg::*;
#(
    parameter int GAP_CYC = 8
) (
    input logic              clk,
    input logic              rst,
    input state_t            state,
    input logic              cmd_oe,
    input logic              cmd_out,
    input logic              abort_pulse,
    input logic              ready,
    input logic [NFLAGS-1:0] flags
);
    logic [7:0]        gap_run;
    logic [NFLAGS-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_run <= '0;
            flags_q <= '0;
        end else begin
            gap_run <= (state == ST_GAP) ? gap_run + 1'b1 : '0;
            flags_q <= flags;
        end
    end

    // R1 / R9: every drive period opens with a low bit
    a_r1_first_bit_low: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_oe) |-> !cmd_out);

    // R7: a timeout only follows the reply wait
    a_r7_timeout_from_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[F_TO]) |-> $past(state) == ST_WAIT);

    // R8: ready returns only after the full idle gap
    a_r8_full_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> gap_run == 8'(GAP_CYC));

    // R9: abort lasts one clock and follows the hold-low state
    a_r9_abort_single: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> !abort_pulse);

    a_r9_abort_after_boot: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> $past(state) == ST_BOOT);

    // R4: the line is released while a reply is shifted in
    a_r4_released_in_reply: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECV) |-> !cmd_oe);

    // R13: one completion per clock
    a_r13_one_new_flag: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags & ~flags_q));
endmodule

bind sdcmd_path sdcmd_path_chk #(.GAP_CYC(GAP_CYC)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .cmd_oe      (cmd_oe),
    .cmd_out     (cmd_out),
    .abort_pulse (abort_pulse),
    .ready       (ready),
    .flags       (flags)
);

// File: tb/test_sdcmd_path.sv
module test_sdcmd_path;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [5:0]   cmd_index = '0;
    logic [31:0]  cmd_arg = '0;
    logic [1:0]   resp_sel = '0;
    logic         wait_pend = 1'b0;
    logic         dpath_ready = 1'b0;
    logic         boot_en = 1'b0;
    logic         boot_mode = 1'b0;
    logic         cmd_in = 1'b1;
    logic         cmd_out, cmd_oe, abort_pulse, ready;
    logic [3:0]   flags;
    logic [3:0]   flags_clr = '0;
    logic [127:0] resp_word;

    int checks = 0;
    int fails = 0;
    int aborts_seen = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdcmd_path i_sdcmd_path (
        .clk(clk), .rst(rst), .start(start), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .resp_sel(resp_sel), .wait_pend(wait_pend), .dpath_ready(dpath_ready),
        .boot_en(boot_en), .boot_mode(boot_mode), .cmd_in(cmd_in), .cmd_out(cmd_out),
        .cmd_oe(cmd_oe), .abort_pulse(abort_pulse), .ready(ready), .flags(flags),
        .flags_clr(flags_clr), .resp_word(resp_word)
    );

    always @(negedge clk) if (abort_pulse) aborts_seen++;

    task automatic chk(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] b_crc(input logic [135:0] v, input int hi, input int lo);
        logic [6:0] c = '0;
        for (int i = hi; i >= lo; i--) begin
            logic fb;
            fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'b0001001;
        end
        return c;
    endfunction

    function automatic logic [47:0] mk_tok(input logic [5:0] idx, input logic [31:0] arg);
        logic [135:0] t;
        t = '0;
        t[47:0] = {1'b0, 1'b1, idx, arg, 7'd0, 1'b1};
        t[7:1] = b_crc(t, 47, 8);
        return t[47:0];
    endfunction

    task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rs);
        cmd_index = idx; cmd_arg = arg; resp_sel = rs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic capture(output logic [47:0] tok, input string req);
        int lim = 0;
        bit oe_ok = 1;
        while (!cmd_oe && lim < 500) begin @(negedge clk); lim++; end
        for (int i = 0; i < 48; i++) begin
            tok[47-i] = cmd_out;
            if (!cmd_oe) oe_ok = 0;
            @(negedge clk);
        end
        chk(oe_ok && !cmd_oe, req, {cmd_oe}, 0);
    endtask

    task automatic drive_resp(input logic [135:0] v, input int len, input int delay);
        repeat (delay) @(negedge clk);
        for (int i = len - 1; i >= 0; i--) begin
            cmd_in = v[i];
            @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    task automatic wait_flag(input int idx);
        int lim = 0;
        while (!flags[idx] && lim < 40) begin @(negedge clk); lim++; end
    endtask

    task automatic settle();
        int lim = 0;
        while (!ready && lim < 300) begin @(negedge clk); lim++; end
        flags_clr = 4'hF;
        @(negedge clk);
        flags_clr = 4'h0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(ready == 1'b1, "R8 reset ready", ready, 1);
        chk(cmd_oe == 1'b0 && cmd_out == 1'b1, "R1 reset line idle", {cmd_oe, cmd_out}, 2'b01);
        chk(flags == 4'h0, "R13 reset flags", flags, 0);
        chk(abort_pulse == 1'b0, "R9 reset abort", abort_pulse, 0);
    endtask

    task automatic t_no_resp_and_gap();
        logic [47:0] tok;
        int n;
        issue(6'd0, 32'h0, 2'b00);
        capture(tok, "R1 drive length");
        chk(tok == 48'h400000000095, "R2 token idx0", tok, 48'h400000000095);
        chk(flags == 4'b0001, "R3 sent flag at end", flags, 4'b0001);
        n = 0;
        while (!ready && n < 20) begin
            start = (n == 1);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(n == 8, "R8 gap length", n, 8);
        n = 0;
        for (int i = 0; i < 4; i++) begin
            if (cmd_oe) n++;
            @(negedge clk);
        end
        chk(n == 0, "R8 start during gap ignored", n, 0);
        settle();
        issue(6'd8, 32'h1AA, 2'b00);
        capture(tok, "R1 drive length");
        chk(tok == 48'h48000001AA87, "R2 token idx8", tok, 48'h48000001AA87);
        settle();
        issue(6'h2A, 32'hDEADBEEF, 2'b00);
        capture(tok, "R1 drive length");
        chk(tok == mk_tok(6'h2A, 32'hDEADBEEF), "R1 token fields", tok, mk_tok(6'h2A, 32'hDEADBEEF));
        settle();
    endtask

    task automatic t_short(input logic [1:0] rs, input bit corrupt, input int exp_flag, input string req);
        logic [47:0] tok;
        logic [135:0] v;
        v = '0;
        v[47:0] = {2'b00, 6'd17, 32'h00000900, 7'd0, 1'b1};
        v[7:1] = b_crc(v, 47, 8) ^ (corrupt ? 7'h10 : 7'h00);
        issue(6'd17, 32'h00000900, rs);
        capture(tok, "R1 drive length");
        drive_resp(v, 48, 2);
        wait_flag(exp_flag);
        chk(flags == (4'b1 << exp_flag), req, flags, 4'b1 << exp_flag);
        chk(resp_word[47:0] == v[47:0], "R4 short reply bits", resp_word[47:0], v[47:0]);
        settle();
    endtask

    task automatic t_long(input bit corrupt, input string req);
        logic [47:0] tok;
        logic [135:0] v;
        int ef;
        v = {2'b00, 6'b111111, 120'hA5C3_0F1E_2D3C_4B5A_6978_8796_A5B4_C3, 7'd0, 1'b1};
        v[7:1] = b_crc(v, 127, 8) ^ (corrupt ? 7'h01 : 7'h00);
        ef = corrupt ? 2 : 1;
        issue(6'd2, 32'h0, 2'b11);
        capture(tok, "R1 drive length");
        drive_resp(v, 136, 5);
        wait_flag(ef);
        chk(flags == (4'b1 << ef), req, flags, 4'b1 << ef);
        chk(resp_word == v[127:0], "R6 long reply bits", resp_word, v[127:0]);
        settle();
    endtask

    task automatic t_timeout();
        logic [47:0] tok;
        logic [135:0] v;
        int n;
        issue(6'd55, 32'h1234, 2'b01);
        capture(tok, "R1 drive length");
        n = 0;
        while (!flags[3] && n < 80) begin @(negedge clk); n++; end
        chk(n == 64, "R7 timeout at 64 clocks", n, 64);
        chk(flags == 4'b1000, "R7 timeout flag only", flags, 4'b1000);
        settle();
        v = '0;
        v[47:0] = {2'b00, 6'd55, 32'hCAFE0001, 7'd0, 1'b1};
        v[7:1] = b_crc(v, 47, 8);
        issue(6'd55, 32'h1234, 2'b01);
        capture(tok, "R1 drive length");
        drive_resp(v, 48, 63);
        wait_flag(1);
        chk(flags == 4'b0010, "R7 start bit on last window clock accepted", flags, 4'b0010);
        settle();
    endtask

    task automatic t_boot_hold();
        int n;
        bit low_ok = 1;
        boot_mode = 1'b0;
        boot_en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            if (!(cmd_oe && !cmd_out)) low_ok = 0;
            @(negedge clk);
        end
        chk(low_ok, "R9 line held low", {cmd_oe, cmd_out}, 2'b10);
        boot_en = 1'b0;
        @(negedge clk);
        chk(abort_pulse && cmd_out && !cmd_oe, "R9 release and abort", {abort_pulse, cmd_out, cmd_oe}, 3'b110);
        n = 0;
        while (!flags[0] && n < 80) begin
            @(negedge clk);
            n++;
            if (n == 1) chk(!abort_pulse, "R9 abort one clock", abort_pulse, 0);
        end
        chk(n == 56, "R10 sent flag after release", n, 56);
        settle();
    endtask

    task automatic t_boot_cmd();
        logic [47:0] tok;
        int a0;
        a0 = aborts_seen;
        boot_mode = 1'b1;
        cmd_index = 6'd0; cmd_arg = 32'h0; resp_sel = 2'b00;
        boot_en = 1'b1;
        @(negedge clk);
        boot_en = 1'b0;
        capture(tok, "R11 token completes after clear");
        chk(tok == 48'h400000000095, "R11 boot command token", tok, 48'h400000000095);
        chk(flags[0] && aborts_seen == a0, "R11 clear has no effect", {flags[0], 1'(aborts_seen != a0)}, 2'b10);
        boot_mode = 1'b0;
        settle();
    endtask

    task automatic t_wait_pend();
        logic [47:0] tok;
        bit quiet = 1;
        wait_pend = 1'b1;
        issue(6'd17, 32'h0BADF00D, 2'b00);
        for (int i = 0; i < 20; i++) begin
            if (cmd_oe) quiet = 0;
            @(negedge clk);
        end
        chk(quiet, "R12 token held", {cmd_oe}, 0);
        cmd_index = 6'd5; cmd_arg = 32'h0;
        dpath_ready = 1'b1;
        @(negedge clk);
        dpath_ready = 1'b0;
        capture(tok, "R12 held token length");
        chk(tok == mk_tok(6'd17, 32'h0BADF00D), "R12 token frozen at accept", tok, mk_tok(6'd17, 32'h0BADF00D));
        settle();
        issue(6'd9, 32'h77, 2'b00);
        repeat (10) @(negedge clk);
        chk(!cmd_oe, "R12 held before release", cmd_oe, 0);
        wait_pend = 1'b0;
        capture(tok, "R12 release by clearing");
        chk(tok == mk_tok(6'd9, 32'h77), "R12 release token", tok, mk_tok(6'd9, 32'h77));
        settle();
    endtask

    task automatic t_w1c();
        logic [47:0] tok;
        issue(6'd1, 32'h0, 2'b00);
        capture(tok, "R1 drive length");
        while (!ready) @(negedge clk);
        issue(6'd1, 32'h0, 2'b01);
        capture(tok, "R1 drive length");
        repeat (70) @(negedge clk);
        chk(flags == 4'b1001, "R13 sticky accumulate", flags, 4'b1001);
        flags_clr = 4'b1000;
        @(negedge clk);
        flags_clr = 4'b0000;
        @(negedge clk);
        chk(flags == 4'b0001, "R13 selective clear", flags, 4'b0001);
        settle();
        chk(flags == 4'b0000, "R13 clear all", flags, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_resp_and_gap();
        t_short(2'b01, 0, 1, "R4 good CRC");
        t_short(2'b01, 1, 2, "R4 CRC error");
        t_short(2'b10, 1, 1, "R5 CRC ignored");
        t_long(0, "R6 long good");
        t_long(1, "R6 long CRC error");
        t_timeout();
        t_boot_hold();
        t_boot_cmd();
        t_wait_pend();
        t_w1c();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule